// File: doc/BRIEF.md
# PCI Interrupt Router with Acknowledge Port

This block gathers the four level-sensitive interrupt pins of every PCI device slot and drives them onto the host's interrupt lines. A static mode input selects the policy. In swizzle mode each pin of each slot is steered onto one of two host lines by parity, so that neighbouring slots spread their load across both lines. In shared mode every PCI interrupt is merged onto host line 0, and host line 1 stays quiet. Each host line is the OR of all inputs mapped to it, so any number of devices may share a line. Host lines are registered.

The block also serves the host's one-byte interrupt-acknowledge read. A byte-wide request is passed to an external interrupt controller by a request/valid handshake. The bus response is held back until the controller supplies a vector, and that vector is returned. A request of any other width is refused at once with an error response and never reaches the controller.

Top module: `pci_irq_router`

## Requirements
- R1: After synchronous reset, host_irq is 0, ack_done and ack_err are 0, and ctl_req is 0.
- R2: Input bit irq_in[slot*NUM_PINS + pin] carries pin `pin` of slot `slot`, where INTA=0, INTB=1, INTC=2 and INTD=3. When shared_mode=0 it maps to host line index (pin + slot) mod 2.
- R3: When shared_mode=0, each host line is high exactly when at least one input mapped to it is high. The lines are level-sensitive and drop once all mapped inputs drop.
- R4: When shared_mode=1, host_irq[0] is the OR of all irq_in bits and host_irq[1] is 0.
- R5: host_irq reflects the irq_in and shared_mode values sampled at the previous rising clock edge, which is a one-cycle latency.
- R6: An acknowledge request with ack_size=0 (one byte), issued while idle, raises ctl_req in the next cycle. ctl_req stays high until a cycle in which ctl_vld is high.
- R7: In the cycle after ctl_vld is seen with ctl_req high, ack_done pulses for one cycle with ack_err=0 and ack_data equal to the ctl_vec of that cycle. ctl_req is 0 in the same cycle.
- R8: An acknowledge request with ack_size 1 (two bytes), 2 (four bytes) or 3 gives ack_done=1, ack_err=1 and ack_data=0 in the next cycle. ctl_req is never raised for it.
- R9: An acknowledge request issued while a byte request is waiting for the controller is ignored. It produces no ack_done and no ack_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shared_mode | input | 1 | 1 selects shared-line routing, 0 selects the parity swizzle |
| irq_in | input | NUM_SLOTS*NUM_PINS | Level interrupt pins, slot-major |
| host_irq | output | 2 | Registered host interrupt lines |
| ack_req | input | 1 | Acknowledge read request, one-cycle pulse |
| ack_size | input | 2 | Access width code: 0 byte, 1 half, 2 word |
| ack_done | output | 1 | Response pulse |
| ack_err | output | 1 | Error flag with ack_done |
| ack_data | output | VEC_W | Returned vector |
| ctl_req | output | 1 | Vector request to the interrupt controller |
| ctl_vld | input | 1 | Controller vector valid |
| ctl_vec | input | VEC_W | Controller vector |

## Verification
The bench builds the block with NUM_SLOTS=4 and NUM_PINS=4. That small configuration has 16 input bits, so all 65536 input patterns can be swept in swizzle mode with a check on every cycle, which covers every slot/pin parity combination and every OR overlap. Shared mode is swept over 4096 patterns that reach every slot. The acknowledge path is driven through each width code, through controller waits of several cycles and through requests made while busy.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  typedef enum logic [0:0] {ACK_IDLE = 1'b0, ACK_WAIT = 1'b1} ack_state_e;
  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam int HOST_LINES = 2;
endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle #(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_PINS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          shared_mode,
  input  logic [NUM_SLOTS*NUM_PINS-1:0] irq_in,
  output logic [1:0]                    host_irq
);
  localparam int NUM_IN = NUM_SLOTS * NUM_PINS;

  logic [NUM_SLOTS-1:0] slot_even, slot_odd;
  logic [1:0]           line_nxt;

  // Per-slot reduction: which pins land on line 0 versus line 1.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_comb begin
      slot_even[s] = 1'b0;
      slot_odd[s]  = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (((s + p) % 2) == 0) slot_even[s] = slot_even[s] | irq_in[s*NUM_PINS+p];
        else                    slot_odd[s]  = slot_odd[s]  | irq_in[s*NUM_PINS+p];
      end
    end
  end

  always_comb begin
    if (shared_mode) line_nxt = {1'b0, |irq_in};
    else             line_nxt = {|slot_odd, |slot_even};
  end

  always_ff @(posedge clk) begin
    if (rst) host_irq <= '0;
    else     host_irq <= line_nxt;
  end

  // R4: line 1 stays quiet in shared mode
  a_r4_shared_line1_low: assert property (@(posedge clk) disable iff (rst)
    $past(shared_mode) && !$past(rst) |-> !host_irq[1]);
  // R3/R5: no input, no interrupt one cycle later
  a_r5_idle_inputs: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_in) == {NUM_IN{1'b0}}) && !$past(rst) |-> host_irq == 2'b00);
  // R4: any asserted input shows on line 0 in shared mode
  a_r4_shared_any: assert property (@(posedge clk) disable iff (rst)
    shared_mode && (|irq_in) |=> host_irq[0]);
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import pci_irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_req,
  input  logic [1:0]       ack_size,
  output logic             ack_done,
  output logic             ack_err,
  output logic [VEC_W-1:0] ack_data,
  output logic             ctl_req,
  input  logic             ctl_vld,
  input  logic [VEC_W-1:0] ctl_vec
);
  ack_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ACK_IDLE;
      ack_done <= 1'b0;
      ack_err  <= 1'b0;
      ack_data <= '0;
      ctl_req  <= 1'b0;
    end else begin
      ack_done <= 1'b0;
      ack_err  <= 1'b0;
      case (st)
        ACK_IDLE: begin
          if (ack_req) begin
            if (ack_size == SIZE_BYTE) begin
              ctl_req <= 1'b1;
              st      <= ACK_WAIT;
            end else begin
              ack_done <= 1'b1;
              ack_err  <= 1'b1;
              ack_data <= '0;
            end
          end
        end
        ACK_WAIT: begin
          if (ctl_vld) begin
            ctl_req  <= 1'b0;
            ack_done <= 1'b1;
            ack_data <= ctl_vec;
            st       <= ACK_IDLE;
          end
        end
        default: st <= ACK_IDLE;
      endcase
    end
  end

  // R6: request held until the controller answers
  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    ctl_req && !ctl_vld |=> ctl_req);
  // R7: returned vector is the one offered by the controller
  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    ctl_req && ctl_vld |=> ack_done && !ack_err && !ctl_req && ack_data == $past(ctl_vec));
  // R8: wide access refused and not forwarded
  a_r8_wide_refused: assert property (@(posedge clk) disable iff (rst)
    (st == ACK_IDLE) && ack_req && (ack_size != SIZE_BYTE) |=> ack_err && ack_done && !ctl_req);
  // R8: error only comes with a response
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
    ack_err |-> ack_done);
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_PINS  = 4,
  parameter int VEC_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          shared_mode,
  input  logic [NUM_SLOTS*NUM_PINS-1:0] irq_in,
  output logic [1:0]                    host_irq,
  input  logic                          ack_req,
  input  logic [1:0]                    ack_size,
  output logic                          ack_done,
  output logic                          ack_err,
  output logic [VEC_W-1:0]              ack_data,
  output logic                          ctl_req,
  input  logic                          ctl_vld,
  input  logic [VEC_W-1:0]              ctl_vec
);
  irq_swizzle #(.NUM_SLOTS(NUM_SLOTS), .NUM_PINS(NUM_PINS)) u_route (
    .clk(clk), .rst(rst), .shared_mode(shared_mode),
    .irq_in(irq_in), .host_irq(host_irq)
  );

  irq_ack_ctrl #(.VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst(rst), .ack_req(ack_req), .ack_size(ack_size),
    .ack_done(ack_done), .ack_err(ack_err), .ack_data(ack_data),
    .ctl_req(ctl_req), .ctl_vld(ctl_vld), .ctl_vec(ctl_vec)
  );
endmodule

// File: tb/sim_pci_irq_router.sv
module sim_pci_irq_router;
  localparam int NS = 4, NP = 4, NI = NS*NP, VW = 8;

  logic clk = 0, rst = 1, shared_mode = 0;
  logic [NI-1:0] irq_in = '0;
  logic [1:0] host_irq, ack_size = 0;
  logic ack_req = 0, ack_done, ack_err, ctl_req, ctl_vld = 0;
  logic [VW-1:0] ack_data, ctl_vec = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pci_irq_router #(.NUM_SLOTS(NS), .NUM_PINS(NP), .VEC_W(VW)) u0 (.*);

  function automatic logic [1:0] expect_lines(input logic [NI-1:0] v, input logic sh);
    logic [1:0] r = 2'b00;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < NP; p++)
        if (v[s*NP+p]) begin
          if (sh) r[0] = 1'b1;
          else    r[(s+p)%2] = 1'b1;
        end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 host_irq", host_irq, 0);
    chk("R1 ack_done", ack_done, 0);
    chk("R1 ctl_req", ctl_req, 0);

    // R2/R3/R5: exhaustive swizzle sweep, checked one cycle after drive
    shared_mode = 0;
    for (int v = 0; v < (1 << NI); v++) begin
      irq_in = v[NI-1:0];
      @(negedge clk);
      chk("R2 R3 R5 swizzle", host_irq, expect_lines(v[NI-1:0], 1'b0));
    end
    // R4: shared mode sweep
    shared_mode = 1;
    for (int v = 0; v < 4096; v++) begin
      irq_in = NI'(v * 16'h9E37) ^ NI'(v);
      @(negedge clk);
      chk("R4 shared", host_irq, expect_lines(irq_in, 1'b1));
    end
    // R3: level drop
    irq_in = '0;
    @(negedge clk);
    chk("R3 drop", host_irq, 0);
    // R5: exact latency
    shared_mode = 0; irq_in = NI'(1);
    #1 chk("R5 not yet", host_irq, 0);
    @(negedge clk);
    chk("R5 one cycle", host_irq, 2'b01);
    irq_in = '0;

    // R6/R7/R9: byte ack with controller wait
    for (int w = 0; w < 3; w++) begin
      ack_req = 1; ack_size = 0;
      @(negedge clk);
      ack_req = 0;
      chk("R6 ctl_req raised", ctl_req, 1);
      chk("R6 no early done", ack_done, 0);
      for (int k = 0; k < w + 2; k++) begin
        ack_req = 1; ack_size = 2'(k % 3);
        @(negedge clk);
        ack_req = 0;
        chk("R9 ignored done", ack_done, 0);
        chk("R9 ignored err", ack_err, 0);
        chk("R6 held", ctl_req, 1);
      end
      ctl_vld = 1; ctl_vec = 8'hA5 ^ 8'(w * 37);
      @(negedge clk);
      ctl_vld = 0;
      chk("R7 done", ack_done, 1);
      chk("R7 err", ack_err, 0);
      chk("R7 data", ack_data, 8'hA5 ^ 8'(w * 37));
      chk("R7 req dropped", ctl_req, 0);
      @(negedge clk);
      chk("R7 pulse", ack_done, 0);
    end

    // R8: wide accesses
    for (int sz = 1; sz < 4; sz++) begin
      ack_req = 1; ack_size = 2'(sz);
      @(negedge clk);
      ack_req = 0;
      chk("R8 done", ack_done, 1);
      chk("R8 err", ack_err, 1);
      chk("R8 data", ack_data, 0);
      chk("R8 no forward", ctl_req, 0);
      @(negedge clk);
      chk("R8 no late forward", ctl_req, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule